// File: doc/BRIEF.md
# Idle and Power-Down Sequencer

This block decides which power state a small 8-bit microcontroller core is in and turns that state into clock enables, a qualified internal reset, a RAM write inhibit and the forced levels of the external bus pins. Software asks for a low-power state with a one-cycle request. An enabled, pending interrupt or the reset pin brings the core back.

The block runs on the oscillator clock `clk`. A machine cycle is `OSC_PER_MC` oscillator periods. The reset pin is acted on only after it has stayed high for `QUAL_MC` machine cycles, which is 24 clocks by default. In the light sleep state the core clock stops and the peripheral clock keeps running. In the deep sleep state the oscillator enable drops as well. Only a qualified reset ends deep sleep, and raising the reset pin restarts the oscillator at once so that the pin can be qualified. `por_n` is the supply-good reset of the block itself.

All control pins are plain level signals. No data stream passes through the block, so it has no valid/ready interface.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `por_n` is low, and after it is released, the block is in the run state: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `rst_int`, `ram_wr_inh` and `pin_force` are 0.
- R2: `rst_int` rises on the 24th consecutive rising edge (with the default parameters) at which `rst_pin` is sampled high. It falls on the first edge at which `rst_pin` is sampled low. A high pulse shorter than 24 edges never raises it.
- R3: In the run state with `rst_int` low, `pd_req` moves the block to deep sleep on the next edge. `idle_req` alone moves it to light sleep. When both are high, deep sleep wins.
- R4: In light sleep, `cpu_clk_en` is 0 and both `per_clk_en` and `osc_en` are 1. A high `irq_pend` returns the block to the run state on the next edge.
- R5: When light sleep sees `rst_pin` high at an edge, the block returns to the run state at that edge and `ram_wr_inh` rises. `ram_wr_inh` falls on the first edge at which `rst_pin` is low or `rst_int` is already high. It never rises in any other case.
- R6: In deep sleep, `cpu_clk_en` and `per_clk_en` are 0 and `osc_en` is 0 unless `rst_pin` is high. `irq_pend`, `idle_req` and `pd_req` have no effect there.
- R7: Deep sleep is left only through reset. `osc_en` follows `rst_pin` without delay, and the run state with all enables at 1 begins on the edge after `rst_int` first reads high.
- R8: `pin_force` is 0 in the run state and 1 in both sleep states. `ale_lvl` and `psen_lvl` are 1 in light sleep and 0 in deep sleep.
- R9: `port_sel` holds 2 bits per port, with port k at bits [2k+1:2k]. The codes are 00 for the port's own latched data, 01 for the address/bus, and 10 for float. With `code_ext`=0 every field is 00. With `code_ext`=1, port 0/port 2 are 01/01 in run, 10/01 in light sleep and 10/00 in deep sleep. Ports 1 and 3 are always 00.
- R10: While `rst_int` is high, `idle_req` and `pd_req` are ignored and the block stays in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous supply-good reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Software request for light sleep |
| pd_req | input | 1 | Software request for deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| code_ext | input | 1 | 1 when code runs from external program memory |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral, timer and serial clock enable |
| osc_en | output | 1 | Oscillator enable |
| rst_int | output | 1 | Qualified internal reset |
| ram_wr_inh | output | 1 | Blocks internal RAM writes |
| pin_force | output | 1 | ALE/PSEN are driven from this block |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-read strobe level |
| port_sel | output | 8 | Per-port output source select |

## Verification
The hardest condition to reach is a reset pin that rises during light sleep and is then either qualified or dropped early. The RAM inhibit window and its two possible endings depend on that timing. Deep sleep combined with reset pulses just short of and just past 24 clocks is a second hard case. A directed phase drives these windows edge by edge. A random phase then draws reset bursts of 1 to 40 clocks, mixed with frequent sleep requests and interrupts, so that both sleep states meet both short and long pulses many times.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'b00,
    SEL_BUS   = 2'b01,
    SEL_FLOAT = 2'b10
  } pin_sel_e;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int QUAL_CNT = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  output logic rst_int
);
  localparam int CW = $clog2(QUAL_CNT + 1);

  logic [CW-1:0] hi_cnt;
  logic          rst_q;

  // hi_cnt counts the edges at which the pin was high; it saturates at the limit
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_cnt <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (!rst_pin)
        hi_cnt <= '0;
      else if (hi_cnt != CW'(QUAL_CNT))
        hi_cnt <= hi_cnt + 1'b1;
      rst_q <= rst_pin && (hi_cnt >= CW'(QUAL_CNT - 1));
    end
  end

  assign rst_int = rst_q;
endmodule

// File: rtl/pmc_state_fsm.sv
module pmc_state_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      rst_pin,
  input  logic      rst_int,
  input  logic      idle_req,
  input  logic      pd_req,
  input  logic      irq_pend,
  output pm_state_e state,
  output logic      ram_wr_inh
);
  pm_state_e st_q, st_d;
  logic      inh_q, inh_d;

  always_comb begin
    st_d = st_q;
    if (rst_int) begin
      st_d = PM_RUN;
    end else begin
      unique case (st_q)
        PM_RUN: begin
          if (pd_req)        st_d = PM_DOWN;
          else if (idle_req) st_d = PM_IDLE;
        end
        PM_IDLE: begin
          if (rst_pin || irq_pend) st_d = PM_RUN;
        end
        PM_DOWN: st_d = PM_DOWN;
        default: st_d = PM_RUN;
      endcase
    end
  end

  // The core wakes from light sleep as soon as the pin rises, and RAM
  // writes stay blocked until the qualified reset takes over.
  always_comb begin
    inh_d = inh_q;
    if (st_q == PM_IDLE && rst_pin && !rst_int)
      inh_d = 1'b1;
    else if (!rst_pin || rst_int)
      inh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= PM_RUN;
      inh_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      inh_q <= inh_d;
    end
  end

  assign state      = st_q;
  assign ram_wr_inh = inh_q;
endmodule

// File: rtl/pmc_pin_mux.sv
module pmc_pin_mux
  import pmc_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int ADDR_LO_PORT = 0,
  parameter int ADDR_HI_PORT = 2
) (
  input  pm_state_e                 state,
  input  logic                      rst_pin,
  input  logic                      code_ext,
  output logic                      cpu_clk_en,
  output logic                      per_clk_en,
  output logic                      osc_en,
  output logic                      pin_force,
  output logic                      ale_lvl,
  output logic                      psen_lvl,
  output logic [2*NUM_PORTS-1:0]    port_sel
);
  assign cpu_clk_en = (state == PM_RUN);
  assign per_clk_en = (state != PM_DOWN);
  // The reset pin restarts the oscillator so that it can be qualified
  assign osc_en     = (state != PM_DOWN) || rst_pin;
  assign pin_force  = (state != PM_RUN);
  assign ale_lvl    = (state == PM_IDLE);
  assign psen_lvl   = (state == PM_IDLE);

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam bit IS_LO = (k == ADDR_LO_PORT);
    localparam bit IS_HI = (k == ADDR_HI_PORT);
    pin_sel_e sel;
    always_comb begin
      sel = SEL_DATA;
      if (code_ext) begin
        if (IS_LO) begin
          sel = (state == PM_RUN) ? SEL_BUS : SEL_FLOAT;
        end else if (IS_HI) begin
          sel = (state == PM_DOWN) ? SEL_DATA : SEL_BUS;
        end
      end
    end
    assign port_sel[2*k +: 2] = sel;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int OSC_PER_MC   = 12,
  parameter int QUAL_MC      = 2,
  parameter int NUM_PORTS    = 4,
  parameter int ADDR_LO_PORT = 0,
  parameter int ADDR_HI_PORT = 2
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_pin,
  input  logic                   idle_req,
  input  logic                   pd_req,
  input  logic                   irq_pend,
  input  logic                   code_ext,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic                   osc_en,
  output logic                   rst_int,
  output logic                   ram_wr_inh,
  output logic                   pin_force,
  output logic                   ale_lvl,
  output logic                   psen_lvl,
  output logic [2*NUM_PORTS-1:0] port_sel
);
  localparam int QUAL_CNT = OSC_PER_MC * QUAL_MC;

  pm_state_e state;

  pmc_rst_qual #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk     (clk),
    .por_n   (por_n),
    .rst_pin (rst_pin),
    .rst_int (rst_int)
  );

  pmc_state_fsm u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin    (rst_pin),
    .rst_int    (rst_int),
    .idle_req   (idle_req),
    .pd_req     (pd_req),
    .irq_pend   (irq_pend),
    .state      (state),
    .ram_wr_inh (ram_wr_inh)
  );

  pmc_pin_mux #(
    .NUM_PORTS    (NUM_PORTS),
    .ADDR_LO_PORT (ADDR_LO_PORT),
    .ADDR_HI_PORT (ADDR_HI_PORT)
  ) u_mux (
    .state      (state),
    .rst_pin    (rst_pin),
    .code_ext   (code_ext),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .pin_force  (pin_force),
    .ale_lvl    (ale_lvl),
    .psen_lvl   (psen_lvl),
    .port_sel   (port_sel)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int QUAL = 24,
  parameter int PW   = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_pin,
  input logic          irq_pend,
  input logic          code_ext,
  input logic          cpu_clk_en,
  input logic          per_clk_en,
  input logic          rst_int,
  input logic          ram_wr_inh,
  input logic          pin_force,
  input logic          ale_lvl,
  input logic [PW-1:0] port_sel
);
  logic [7:0] hi_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_run <= '0;
    else if (!rst_pin) hi_run <= '0;
    else if (hi_run != 8'hff) hi_run <= hi_run + 1'b1;
  end

  // R2: qualified reset only after a long enough high run of the pin
  a_r2_qualified: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_int) |-> (hi_run >= 8'(QUAL)));

  // R4: light sleep keeps peripherals clocked, stops the core
  a_r4_idle_clocks: assert property (@(posedge clk) disable iff (!por_n)
    (pin_force && ale_lvl) |-> (!cpu_clk_en && per_clk_en));

  // R4: a pending interrupt ends light sleep at the next edge
  a_r4_irq_wake: assert property (@(posedge clk) disable iff (!por_n)
    (pin_force && ale_lvl && irq_pend && !rst_int) |=> cpu_clk_en);

  // R5: the RAM inhibit is raised only by the reset pin
  a_r5_inh_src: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ram_wr_inh) |-> ($past(rst_pin) && cpu_clk_en));

  // R6: deep sleep stops all clocks and holds without a reset
  a_r6_pd_clocks: assert property (@(posedge clk) disable iff (!por_n)
    (pin_force && !ale_lvl) |-> (!cpu_clk_en && !per_clk_en));

  a_r6_pd_holds: assert property (@(posedge clk) disable iff (!por_n)
    (pin_force && !ale_lvl && !rst_int) |=> (pin_force && !ale_lvl));

  // R8: no forcing while running
  a_r8_run_free: assert property (@(posedge clk) disable iff (!por_n)
    cpu_clk_en |-> !pin_force);

  // R9: internal code leaves every port on its own data
  a_r9_internal: assert property (@(posedge clk) disable iff (!por_n)
    !code_ext |-> (port_sel == '0));

  // R10: while in reset, no sleep is entered
  a_r10_rst_run: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |=> cpu_clk_en);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .QUAL (OSC_PER_MC * QUAL_MC),
  .PW   (2 * NUM_PORTS)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_pin    (rst_pin),
  .irq_pend   (irq_pend),
  .code_ext   (code_ext),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .rst_int    (rst_int),
  .ram_wr_inh (ram_wr_inh),
  .pin_force  (pin_force),
  .ale_lvl    (ale_lvl),
  .port_sel   (port_sel)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0, code_ext = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, rst_int, ram_wr_inh, pin_force, ale_lvl, psen_lvl;
  logic [7:0] port_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_pend(irq_pend), .code_ext(code_ext),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .rst_int(rst_int), .ram_wr_inh(ram_wr_inh), .pin_force(pin_force),
    .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .port_sel(port_sel)
  );

  localparam logic [1:0] S_RUN = 2'd0, S_IDLE = 2'd1, S_DOWN = 2'd2;
  localparam int QUAL = 24;

  // Reference model built from the requirements
  logic [1:0] m_st;
  int         m_cnt;
  logic       m_rst, m_inh;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st <= S_RUN; m_cnt <= 0; m_rst <= 1'b0; m_inh <= 1'b0;
    end else begin
      m_cnt <= rst_pin ? ((m_cnt < QUAL) ? m_cnt + 1 : m_cnt) : 0;
      m_rst <= rst_pin && (m_cnt + 1 >= QUAL);
      if (m_rst) m_st <= S_RUN;
      else if (m_st == S_RUN) begin
        if (pd_req) m_st <= S_DOWN;
        else if (idle_req) m_st <= S_IDLE;
      end else if (m_st == S_IDLE && (rst_pin || irq_pend)) m_st <= S_RUN;
      if (m_st == S_IDLE && rst_pin && !m_rst) m_inh <= 1'b1;
      else if (!rst_pin || m_rst) m_inh <= 1'b0;
    end
  end

  function automatic logic [7:0] exp_sel(input logic [1:0] st, input logic ext);
    logic [1:0] p0, p2;
    p0 = 2'b00; p2 = 2'b00;
    if (ext) begin
      case (st)
        S_RUN:  begin p0 = 2'b01; p2 = 2'b01; end
        S_IDLE: begin p0 = 2'b10; p2 = 2'b01; end
        default: begin p0 = 2'b10; p2 = 2'b00; end
      endcase
    end
    return {2'b00, p2, 2'b00, p0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Full comparison against the model, away from both clock edges
  always @(posedge clk) begin
    #3;
    if (por_n && !done) begin
      chk("R2 rst_int", rst_int, m_rst);
      chk("R4/R6 cpu_clk_en", cpu_clk_en, m_st == S_RUN);
      chk("R4/R6 per_clk_en", per_clk_en, m_st != S_DOWN);
      chk("R7 osc_en", osc_en, (m_st != S_DOWN) || rst_pin);
      chk("R5 ram_wr_inh", ram_wr_inh, m_inh);
      chk("R8 pin_force", pin_force, m_st != S_RUN);
      chk("R8 ale/psen", {ale_lvl, psen_lvl}, (m_st == S_IDLE) ? 2'b11 : 2'b00);
      chk("R9 port_sel", port_sel, exp_sel(m_st, code_ext));
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    edges(3);
    chk("R1 reset clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R1 reset flags", {rst_int, ram_wr_inh, pin_force}, 3'b000);
    por_n = 1'b1;
    code_ext = 1'b1;
    edges(2);
    chk("R1 run after release", {cpu_clk_en, pin_force}, 2'b10);
    chk("R9 run external", port_sel, 8'h11);

    // light sleep then interrupt wake
    idle_req = 1'b1; edges(1); idle_req = 1'b0;
    chk("R3 idle entered", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
    chk("R8 idle strobes", {pin_force, ale_lvl, psen_lvl}, 3'b111);
    chk("R9 idle external", port_sel, 8'h12);
    edges(3);
    chk("R4 idle holds", cpu_clk_en, 1'b0);
    irq_pend = 1'b1; edges(1); irq_pend = 1'b0;
    chk("R4 irq wake", cpu_clk_en, 1'b1);

    // both requests: deep sleep wins
    pd_req = 1'b1; idle_req = 1'b1; edges(1); pd_req = 1'b0; idle_req = 1'b0;
    chk("R3 pd priority", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
    chk("R8 pd strobes", {pin_force, ale_lvl, psen_lvl}, 3'b100);
    chk("R9 pd external", port_sel, 8'h02);
    irq_pend = 1'b1; idle_req = 1'b1; edges(4); irq_pend = 1'b0; idle_req = 1'b0;
    chk("R6 irq ignored in pd", {cpu_clk_en, pin_force, ale_lvl}, 3'b010);

    // short reset pulse: oscillator restarts, no reset, stays asleep
    rst_pin = 1'b1; #1;
    chk("R7 osc follows pin", osc_en, 1'b1);
    edges(QUAL - 1);
    chk("R2 23 edges not enough", rst_int, 1'b0);
    rst_pin = 1'b0; #1;
    chk("R6 osc off again", osc_en, 1'b0);
    edges(2);
    chk("R6 still pd", {cpu_clk_en, pin_force}, 2'b01);

    // long pulse: qualified at edge 24, running one edge later
    rst_pin = 1'b1;
    edges(QUAL);
    chk("R2 qualified at 24", rst_int, 1'b1);
    chk("R7 not yet running", cpu_clk_en, 1'b0);
    pd_req = 1'b1; idle_req = 1'b1;
    edges(1);
    chk("R7 running after reset", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    edges(2);
    chk("R10 requests ignored in reset", {cpu_clk_en, pin_force}, 2'b10);
    pd_req = 1'b0; idle_req = 1'b0; rst_pin = 1'b0;
    edges(1);
    chk("R2 falls on low pin", rst_int, 1'b0);

    // light sleep ended by reset pin: inhibit window
    idle_req = 1'b1; edges(1); idle_req = 1'b0;
    rst_pin = 1'b1; edges(1);
    chk("R5 wake on pin", {cpu_clk_en, ram_wr_inh}, 2'b11);
    edges(QUAL - 1);
    chk("R5 inhibit overlaps reset", {rst_int, ram_wr_inh}, 2'b11);
    edges(1);
    chk("R5 inhibit released", ram_wr_inh, 1'b0);
    rst_pin = 1'b0; edges(1);

    // light sleep, pin glitch drops inhibit
    idle_req = 1'b1; edges(1); idle_req = 1'b0;
    rst_pin = 1'b1; edges(3); rst_pin = 1'b0; edges(1);
    chk("R5 aborted window", {ram_wr_inh, rst_int, cpu_clk_en}, 3'b001);

    // internal code keeps ports on data
    code_ext = 1'b0;
    idle_req = 1'b1; edges(1); idle_req = 1'b0;
    chk("R9 internal idle", port_sel, 8'h00);
    irq_pend = 1'b1; edges(1); irq_pend = 1'b0;

    // random phase, checked by the model
    begin
      int burst = 0;
      for (int i = 0; i < 6000; i++) begin
        if (burst > 0) begin
          burst--;
          rst_pin = (burst != 0);
        end else if ($urandom_range(0, 59) == 0) begin
          burst = $urandom_range(1, 40);
          rst_pin = 1'b1;
        end
        idle_req = ($urandom_range(0, 7) == 0);
        pd_req   = ($urandom_range(0, 29) == 0);
        irq_pend = ($urandom_range(0, 9) == 0);
        if ($urandom_range(0, 49) == 0) code_ext = ~code_ext;
        edges(1);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule